// File: doc/BRIEF.md
# Dual-Task Video Scheduler

This block decides, field by field, which of two programmed processing tasks (A or B) drives a downstream video scaler. For each task it holds the configuration: an enable bit, a start trigger code, a repeat bit, a field-skip count, and an acquisition window given as a first line, a pixel column and a height in lines. The block watches a vertical sync pulse, a field identity bit and the running line and pixel counters. It raises a strobe for as long as the chosen task's window is being processed, and it reports which task owns that window.

When a task is selected, the block copies that task's configuration into working registers and arms a trigger. After the trigger condition is met, the task waits for the window's start position. Each qualifying field is first used up against the skip count. The next qualifying field then runs. When a run ends, the same task runs again once if its repeat bit is set. Otherwise the other task takes over on the next clock. A toggle output flips every time a run begins, so later stages can tell consecutive outputs apart. An active-low software reset, synchronised to the video clock, returns everything to idle at once.

Top module: `dts_sched`

## Requirements
- R1: After power-on or a software reset, `task_active` is 0, `toggle` is 0 and `task_sel` is 1, where task_sel 0 means task A and 1 means task B.
- R2: A task whose enable bit is 0 is never selected. With both enable bits at 0, `task_active` never rises.
- R3: After a reset with both tasks enabled, the first task to run is B.
- R4: With trigger code 1 (vertical sync), a run begins at the first window start point after a vsync that follows selection. `task_active` rises one clock after the cycle in which line_cnt equals the start line and pix_cnt equals the start column.
- R5: With trigger code 2 a run begins only at a start point where fid is 0. With code 3 it begins only where fid is 1. A start point with the wrong fid makes the task wait for the next vsync.
- R6: With trigger code 0 (immediate) the task is armed at selection. If the counters are already past its start point, it runs in the next field. If not, it runs in the current field.
- R7: A run lasts from the start point until line_cnt equals start line plus height while pix_cnt equals the start column, which is height × line-length cycles. A handover selects the next task on the following clock.
- R8: With the repeat bit at 1, a task runs twice in a row before control passes to the other task. With the bit at 0, it hands over after one run.
- R9: A task skips as many qualifying fields as its 3-bit skip count (0 to 7) before it runs.
- R10: `toggle` flips at every rise of `task_active` and changes at no other time except to return to 0 on reset.
- R11: A low level on `sw_rst_n` forces idle within three clocks, because it passes through a two-stage synchroniser.
- R12: A task's configuration is captured when the task is selected. Changing its inputs during a run does not change that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sw_rst_n | input | 1 | Active-low software reset, asynchronous to clk |
| vsync | input | 1 | One-cycle vertical sync pulse |
| fid | input | 1 | Field identity bit |
| line_cnt | input | LINE_W | Current line number |
| pix_cnt | input | PIX_W | Current pixel number in the line |
| a_en | input | 1 | Task A enable |
| a_trig | input | 2 | Task A trigger code (0 immediate, 1 vsync, 2 fid=0, 3 fid=1) |
| a_rpt | input | 1 | Task A repeat bit |
| a_skip | input | SKIP_W | Task A field-skip count |
| a_yofs | input | LINE_W | Task A start line |
| a_xofs | input | PIX_W | Task A start column |
| a_ylen | input | LINE_W | Task A window height in lines |
| b_en | input | 1 | Task B enable |
| b_trig | input | 2 | Task B trigger code |
| b_rpt | input | 1 | Task B repeat bit |
| b_skip | input | SKIP_W | Task B field-skip count |
| b_yofs | input | LINE_W | Task B start line |
| b_xofs | input | PIX_W | Task B start column |
| b_ylen | input | LINE_W | Task B window height in lines |
| task_sel | output | 1 | Task owning the scheduler (0 A, 1 B) |
| task_active | output | 1 | High while a run is in progress |
| toggle | output | 1 | Flips at every run start |

## Verification
The checker confirms on every cycle that a run starts exactly one clock after the counters hit the captured start point, and that the fid sampled there matches a field-polarity trigger. It also confirms that `toggle` moves only when a run begins, that `task_sel` holds steady through a run, and that the synchronised software reset leaves the block idle on the next clock. Some properties span many fields: the B-first order, the alternation and repeat patterns, skip spacing, the immediate-trigger same-field versus next-field outcome, run length, and configuration capture. Only the bench shows these, by sweeping trigger codes, repeat and skip settings over a small raster and comparing the logged runs with counts it works out itself.

// File: rtl/dts_pkg.sv
`timescale 1ns/1ps
package dts_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    TRG_IMM   = 2'd0,
    TRG_VSYNC = 2'd1,
    TRG_FID0  = 2'd2,
    TRG_FID1  = 2'd3
  } trig_e;

  localparam int  NTASK  = 2;
  localparam logic TASK_A = 1'b0;
  localparam logic TASK_B = 1'b1;

endpackage

// File: rtl/dts_rst_sync.sv
`timescale 1ns/1ps
// Shift-register synchroniser with asynchronous clear.
// Used for the power-on reset (din tied high) and for the software reset level.
module dts_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      shreg <= '0;
    end else begin
      shreg <= {shreg[STAGES-2:0], din};
    end
  end

  assign dout = shreg[STAGES-1];

endmodule

// File: rtl/dts_trigger.sv
`timescale 1ns/1ps
// Start-condition evaluation for the task currently waiting.
module dts_trigger
  import dts_pkg::*;
#(
  parameter int LINE_W = 11,
  parameter int PIX_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst,
  input  logic              load,
  input  trig_e             ld_trig,
  input  logic              waiting,
  input  trig_e             lat_trig,
  input  logic [LINE_W-1:0] lat_yofs,
  input  logic [PIX_W-1:0]  lat_xofs,
  input  logic              vsync,
  input  logic              fid,
  input  logic [LINE_W-1:0] line_cnt,
  input  logic [PIX_W-1:0]  pix_cnt,
  output logic              fire
);

  logic armed;
  logic armed_n;
  logic arm_we;
  logic ofs_hit;
  logic cond_ok;

  assign ofs_hit = (line_cnt == lat_yofs) && (pix_cnt == lat_xofs);

  always_comb begin
    case (lat_trig)
      TRG_FID0: cond_ok = !fid;
      TRG_FID1: cond_ok = fid;
      default:  cond_ok = 1'b1;
    endcase
  end

  // Arming: immediate tasks are armed at selection, all others by a vsync.
  // A start point reached without firing (or fired on a non-immediate
  // trigger) disarms until the next vsync.
  always_comb begin
    armed_n = armed;
    arm_we  = 1'b0;
    if (srst) begin
      armed_n = 1'b0;
      arm_we  = 1'b1;
    end else if (load) begin
      armed_n = (ld_trig == TRG_IMM);
      arm_we  = 1'b1;
    end else if (waiting) begin
      if (vsync) begin
        armed_n = 1'b1;
        arm_we  = 1'b1;
      end else if (ofs_hit && (lat_trig != TRG_IMM)) begin
        armed_n = 1'b0;
        arm_we  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
    end else if (arm_we) begin
      armed <= armed_n;
    end
  end

  assign fire = waiting && armed && ofs_hit && cond_ok;

endmodule

// File: rtl/dts_seq.sv
`timescale 1ns/1ps
// Task sequencer: selection, configuration capture, skip, run, repeat, handover.
module dts_seq
  import dts_pkg::*;
#(
  parameter int LINE_W = 11,
  parameter int PIX_W  = 12,
  parameter int SKIP_W = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          srst,
  input  logic [NTASK-1:0]              en_v,
  input  logic [NTASK-1:0]              rpt_v,
  input  logic [NTASK-1:0][1:0]         trig_v,
  input  logic [NTASK-1:0][SKIP_W-1:0]  skip_v,
  input  logic [NTASK-1:0][LINE_W-1:0]  yofs_v,
  input  logic [NTASK-1:0][LINE_W-1:0]  ylen_v,
  input  logic [NTASK-1:0][PIX_W-1:0]   xofs_v,
  input  logic [LINE_W-1:0]             line_cnt,
  input  logic [PIX_W-1:0]              pix_cnt,
  input  logic                          fire,
  output logic                          load,
  output trig_e                         ld_trig,
  output logic                          waiting,
  output trig_e                         lat_trig,
  output logic [LINE_W-1:0]             lat_yofs,
  output logic [PIX_W-1:0]              lat_xofs,
  output logic                          task_sel,
  output logic                          task_active,
  output logic                          toggle
);

  localparam logic [SKIP_W-1:0] SKIP_ONE = SKIP_W'(1);

  seq_state_e         state, state_n;
  logic               cur, cur_n;
  logic               pref, pref_n;
  logic               tog, tog_n;
  logic               rep_done, rep_n;
  logic [SKIP_W-1:0]  skip_left, skip_n;
  logic               ld_sel;
  logic               lat_rpt;
  logic [LINE_W-1:0]  lat_yend;
  logic               end_hit;
  logic [1:0]         pick_a;
  logic [1:0]         pick_b;
  logic [NTASK-1:0][LINE_W-1:0] yend_v;

  // Window end line per task.
  for (genvar t = 0; t < NTASK; t++) begin : g_yend
    assign yend_v[t] = yofs_v[t] + ylen_v[t];
  end

  // Returns {valid, task}: preferred task if enabled, else the other one.
  function automatic logic [1:0] pick(input logic first, input logic [NTASK-1:0] en);
    logic [1:0] r;
    if (en[first]) begin
      r = {1'b1, first};
    end else if (en[~first]) begin
      r = {1'b1, ~first};
    end else begin
      r = {1'b0, first};
    end
    return r;
  endfunction

  assign pick_a  = pick(pref, en_v);
  assign pick_b  = pick(~cur, en_v);
  assign end_hit = (line_cnt == lat_yend) && (pix_cnt == lat_xofs);

  always_comb begin
    state_n = state;
    cur_n   = cur;
    pref_n  = pref;
    tog_n   = tog;
    rep_n   = rep_done;
    skip_n  = skip_left;
    load    = 1'b0;
    ld_sel  = cur;
    case (state)
      ST_IDLE: begin
        if (pick_a[1]) begin
          load    = 1'b1;
          ld_sel  = pick_a[0];
          cur_n   = pick_a[0];
          rep_n   = 1'b0;
          skip_n  = skip_v[pick_a[0]];
          state_n = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (fire) begin
          if (skip_left != '0) begin
            skip_n = skip_left - SKIP_ONE;
          end else begin
            tog_n   = ~tog;
            state_n = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        if (end_hit) begin
          if (lat_rpt && !rep_done) begin
            load    = 1'b1;
            ld_sel  = cur;
            rep_n   = 1'b1;
            skip_n  = skip_v[cur];
            state_n = ST_WAIT;
          end else begin
            pref_n = ~cur;
            rep_n  = 1'b0;
            if (pick_b[1]) begin
              load    = 1'b1;
              ld_sel  = pick_b[0];
              cur_n   = pick_b[0];
              skip_n  = skip_v[pick_b[0]];
              state_n = ST_WAIT;
            end else begin
              state_n = ST_IDLE;
            end
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
    if (srst) begin
      state_n = ST_IDLE;
      cur_n   = TASK_B;
      pref_n  = TASK_B;
      tog_n   = 1'b0;
      rep_n   = 1'b0;
      skip_n  = '0;
      load    = 1'b0;
    end
  end

  assign ld_trig = trig_e'(trig_v[ld_sel]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur       <= TASK_B;
      pref      <= TASK_B;
      tog       <= 1'b0;
      rep_done  <= 1'b0;
      skip_left <= '0;
    end else begin
      state     <= state_n;
      cur       <= cur_n;
      pref      <= pref_n;
      tog       <= tog_n;
      rep_done  <= rep_n;
      skip_left <= skip_n;
    end
  end

  // Captured configuration, written only when a task is selected.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_trig <= TRG_IMM;
      lat_rpt  <= 1'b0;
      lat_yofs <= '0;
      lat_xofs <= '0;
      lat_yend <= '0;
    end else if (load) begin
      lat_trig <= ld_trig;
      lat_rpt  <= rpt_v[ld_sel];
      lat_yofs <= yofs_v[ld_sel];
      lat_xofs <= xofs_v[ld_sel];
      lat_yend <= yend_v[ld_sel];
    end
  end

  assign waiting     = (state == ST_WAIT);
  assign task_active = (state == ST_RUN);
  assign task_sel    = cur;
  assign toggle      = tog;

endmodule

// File: rtl/dts_sched.sv
`timescale 1ns/1ps
module dts_sched
  import dts_pkg::*;
#(
  parameter int LINE_W      = 11,
  parameter int PIX_W       = 12,
  parameter int SKIP_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_rst_n,
  input  logic              vsync,
  input  logic              fid,
  input  logic [LINE_W-1:0] line_cnt,
  input  logic [PIX_W-1:0]  pix_cnt,
  input  logic              a_en,
  input  logic [1:0]        a_trig,
  input  logic              a_rpt,
  input  logic [SKIP_W-1:0] a_skip,
  input  logic [LINE_W-1:0] a_yofs,
  input  logic [PIX_W-1:0]  a_xofs,
  input  logic [LINE_W-1:0] a_ylen,
  input  logic              b_en,
  input  logic [1:0]        b_trig,
  input  logic              b_rpt,
  input  logic [SKIP_W-1:0] b_skip,
  input  logic [LINE_W-1:0] b_yofs,
  input  logic [PIX_W-1:0]  b_xofs,
  input  logic [LINE_W-1:0] b_ylen,
  output logic              task_sel,
  output logic              task_active,
  output logic              toggle
);

  logic rst_int_n;
  logic sw_ok;
  logic srst;
  logic load;
  logic waiting;
  logic fire;
  trig_e ld_trig;
  trig_e lat_trig;
  logic [LINE_W-1:0] lat_yofs;
  logic [PIX_W-1:0]  lat_xofs;

  logic [NTASK-1:0]             en_v;
  logic [NTASK-1:0]             rpt_v;
  logic [NTASK-1:0][1:0]        trig_v;
  logic [NTASK-1:0][SKIP_W-1:0] skip_v;
  logic [NTASK-1:0][LINE_W-1:0] yofs_v;
  logic [NTASK-1:0][LINE_W-1:0] ylen_v;
  logic [NTASK-1:0][PIX_W-1:0]  xofs_v;

  assign en_v   = {b_en,   a_en};
  assign rpt_v  = {b_rpt,  a_rpt};
  assign trig_v = {b_trig, a_trig};
  assign skip_v = {b_skip, a_skip};
  assign yofs_v = {b_yofs, a_yofs};
  assign ylen_v = {b_ylen, a_ylen};
  assign xofs_v = {b_xofs, a_xofs};

  dts_rst_sync #(.STAGES(SYNC_STAGES)) u_por_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .din    (1'b1),
    .dout   (rst_int_n)
  );

  dts_rst_sync #(.STAGES(SYNC_STAGES)) u_sw_sync (
    .clk    (clk),
    .arst_n (rst_int_n),
    .din    (sw_rst_n),
    .dout   (sw_ok)
  );

  assign srst = !sw_ok;

  dts_seq #(.LINE_W(LINE_W), .PIX_W(PIX_W), .SKIP_W(SKIP_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .srst        (srst),
    .en_v        (en_v),
    .rpt_v       (rpt_v),
    .trig_v      (trig_v),
    .skip_v      (skip_v),
    .yofs_v      (yofs_v),
    .ylen_v      (ylen_v),
    .xofs_v      (xofs_v),
    .line_cnt    (line_cnt),
    .pix_cnt     (pix_cnt),
    .fire        (fire),
    .load        (load),
    .ld_trig     (ld_trig),
    .waiting     (waiting),
    .lat_trig    (lat_trig),
    .lat_yofs    (lat_yofs),
    .lat_xofs    (lat_xofs),
    .task_sel    (task_sel),
    .task_active (task_active),
    .toggle      (toggle)
  );

  dts_trigger #(.LINE_W(LINE_W), .PIX_W(PIX_W)) u_trig (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .srst     (srst),
    .load     (load),
    .ld_trig  (ld_trig),
    .waiting  (waiting),
    .lat_trig (lat_trig),
    .lat_yofs (lat_yofs),
    .lat_xofs (lat_xofs),
    .vsync    (vsync),
    .fid      (fid),
    .line_cnt (line_cnt),
    .pix_cnt  (pix_cnt),
    .fire     (fire)
  );

endmodule

// File: rtl/dts_sched_chk.sv
`timescale 1ns/1ps
module dts_sched_chk #(
  parameter int LINE_W = 11,
  parameter int PIX_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              srst,
  input logic              task_active,
  input logic              task_sel,
  input logic              toggle,
  input logic              fid,
  input logic [LINE_W-1:0] line_cnt,
  input logic [PIX_W-1:0]  pix_cnt,
  input logic [1:0]        lat_trig,
  input logic [LINE_W-1:0] lat_yofs,
  input logic [PIX_W-1:0]  lat_xofs
);

  assert_start_at_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(task_active) |-> ($past(line_cnt) == $past(lat_yofs)) && ($past(pix_cnt) == $past(lat_xofs)));

  assert_fid0_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(task_active) && ($past(lat_trig) == 2'd2)) |-> ($past(fid) == 1'b0));

  assert_fid1_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(task_active) && ($past(lat_trig) == 2'd3)) |-> ($past(fid) == 1'b1));

  assert_sel_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (task_active && $past(task_active)) |-> $stable(task_sel));

  assert_toggle_flips_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(task_active) |-> (toggle != $past(toggle)));

  assert_toggle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(toggle) |-> ($rose(task_active) || !toggle));

  assert_srst_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (!task_active && !toggle && task_sel));

endmodule

bind dts_sched dts_sched_chk #(.LINE_W(LINE_W), .PIX_W(PIX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .srst        (srst),
  .task_active (task_active),
  .task_sel    (task_sel),
  .toggle      (toggle),
  .fid         (fid),
  .line_cnt    (line_cnt),
  .pix_cnt     (pix_cnt),
  .lat_trig    (lat_trig),
  .lat_yofs    (lat_yofs),
  .lat_xofs    (lat_xofs)
);

// File: tb/tb_dts_sched.sv
`timescale 1ns/1ps
module tb_dts_sched;

  localparam int LW = 11;
  localparam int PW = 12;
  localparam int SW = 3;
  localparam int NL = 32;
  localparam int NP = 8;
  localparam int FC = NL * NP;

  logic clk = 1'b0;
  logic rst_n, sw_rst_n, vsync, fid;
  logic [LW-1:0] line_cnt;
  logic [PW-1:0] pix_cnt;
  logic a_en, a_rpt, b_en, b_rpt;
  logic [1:0] a_trig, b_trig;
  logic [SW-1:0] a_skip, b_skip;
  logic [LW-1:0] a_yofs, a_ylen, b_yofs, b_ylen;
  logic [PW-1:0] a_xofs, b_xofs;
  logic task_sel, task_active, toggle;

  int checks = 0;
  int errors = 0;
  int fld = 0;

  int log_n = 0;
  int ev_fld [64];
  int ev_line[64];
  int ev_sel [64];
  int ev_tog [64];
  int ev_len [64];
  int run_len = 0;
  logic act_q = 1'b0;

  always #10 clk = ~clk;

  dts_sched #(.LINE_W(LW), .PIX_W(PW), .SKIP_W(SW)) dut (
    .clk(clk), .rst_n(rst_n), .sw_rst_n(sw_rst_n), .vsync(vsync), .fid(fid),
    .line_cnt(line_cnt), .pix_cnt(pix_cnt),
    .a_en(a_en), .a_trig(a_trig), .a_rpt(a_rpt), .a_skip(a_skip),
    .a_yofs(a_yofs), .a_xofs(a_xofs), .a_ylen(a_ylen),
    .b_en(b_en), .b_trig(b_trig), .b_rpt(b_rpt), .b_skip(b_skip),
    .b_yofs(b_yofs), .b_xofs(b_xofs), .b_ylen(b_ylen),
    .task_sel(task_sel), .task_active(task_active), .toggle(toggle)
  );

  // Raster generator: NL lines of NP pixels, fid = field parity.
  initial begin
    int ln = NL - 1;
    int px = NP - 1;
    line_cnt = '0; pix_cnt = '0; vsync = 1'b0; fid = 1'b0;
    forever begin
      @(negedge clk);
      px++;
      if (px == NP) begin
        px = 0;
        ln++;
        if (ln == NL) begin
          ln = 0;
          fld++;
        end
      end
      line_cnt = LW'(ln);
      pix_cnt  = PW'(px);
      vsync    = (ln == 0) && (px == 0);
      fid      = fld[0];
    end
  end

  // Run logger.
  always @(negedge clk) begin
    #1;
    if (task_active && !act_q) begin
      if (log_n < 64) begin
        ev_fld[log_n]  = fld;
        ev_line[log_n] = int'(line_cnt);
        ev_sel[log_n]  = int'(task_sel);
        ev_tog[log_n]  = int'(toggle);
        ev_len[log_n]  = -1;
        log_n++;
      end
      run_len = 1;
    end else if (task_active) begin
      run_len++;
    end
    if (!task_active && act_q && log_n > 0) ev_len[log_n-1] = run_len;
    act_q = task_active;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_a(input logic en, input int trig, input logic rpt, input int skip,
                       input int yofs, input int xofs, input int ylen);
    a_en = en; a_trig = 2'(trig); a_rpt = rpt; a_skip = SW'(skip);
    a_yofs = LW'(yofs); a_xofs = PW'(xofs); a_ylen = LW'(ylen);
  endtask

  task automatic set_b(input logic en, input int trig, input logic rpt, input int skip,
                       input int yofs, input int xofs, input int ylen);
    b_en = en; b_trig = 2'(trig); b_rpt = rpt; b_skip = SW'(skip);
    b_yofs = LW'(yofs); b_xofs = PW'(xofs); b_ylen = LW'(ylen);
  endtask

  task automatic sw_reset();
    @(negedge clk);
    sw_rst_n = 1'b0;
    repeat (4) @(negedge clk);
    sw_rst_n = 1'b1;
    repeat (2) @(negedge clk);
    log_n = 0;
  endtask

  task automatic run_fields(input int n);
    repeat (n * FC) @(negedge clk);
  endtask

  task automatic wait_runs(input int n);
    for (int i = 0; i < 4 * FC && log_n < n; i++) @(negedge clk);
  endtask

  // Watchdog.
  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    sw_rst_n = 1'b1;
    set_a(1'b0, 1, 1'b0, 0, 4, 2, 4);
    set_b(1'b0, 1, 1'b0, 0, 4, 2, 4);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1: reset state
    check("R1 active after reset", int'(task_active), 0);
    check("R1 toggle after reset", int'(toggle), 0);
    check("R1 sel after reset", int'(task_sel), 1);
    log_n = 0;

    // R2: both disabled stays idle
    run_fields(3);
    check("R2 no runs with both disabled", log_n, 0);

    // Alternation with vsync trigger: R3 R4 R7 R8 R10
    set_a(1'b1, 1, 1'b0, 0, 4, 2, 4);
    set_b(1'b1, 1, 1'b0, 0, 4, 2, 4);
    sw_reset();
    run_fields(6);
    check("R4 runs logged", int'(log_n >= 5), 1);
    check("R3 first run is B", ev_sel[0], 1);
    for (int k = 0; k < log_n; k++) begin
      check("R8 alternating owner", ev_sel[k], (k % 2 == 0) ? 1 : 0);
      check("R10 toggle per run", ev_tog[k], (k % 2 == 0) ? 1 : 0);
      check("R4 start line", ev_line[k], 4);
      if (ev_len[k] >= 0) check("R7 run length", ev_len[k], 4 * NP);
      if (k > 0) check("R7 handover next field", ev_fld[k] - ev_fld[k-1], 1);
    end

    // R9 skip with A alone (also R2: B never chosen)
    set_a(1'b1, 1, 1'b0, 2, 4, 2, 4);
    set_b(1'b0, 1, 1'b0, 0, 4, 2, 4);
    sw_reset();
    run_fields(11);
    check("R9 runs logged", int'(log_n >= 3), 1);
    for (int k = 0; k < log_n; k++) begin
      check("R2 disabled B never selected", ev_sel[k], 0);
      if (k > 0) check("R9 skip spacing", ev_fld[k] - ev_fld[k-1], 3);
    end

    // R8 repeat on A only
    set_a(1'b1, 1, 1'b1, 0, 4, 2, 4);
    set_b(1'b1, 1, 1'b0, 0, 4, 2, 4);
    sw_reset();
    run_fields(8);
    check("R8 runs logged", int'(log_n >= 6), 1);
    for (int k = 0; k < log_n; k++)
      check("R8 repeat pattern", ev_sel[k], (k % 3 == 0) ? 1 : 0);

    // R5 field polarity triggers
    for (int pol = 0; pol < 2; pol++) begin
      set_a(1'b1, 2 + pol, 1'b0, 0, 4, 2, 4);
      set_b(1'b0, 1, 1'b0, 0, 4, 2, 4);
      sw_reset();
      run_fields(8);
      check("R5 runs logged", int'(log_n >= 3), 1);
      for (int k = 0; k < log_n; k++) begin
        check("R5 fid of run field", ev_fld[k] % 2, pol);
        if (k > 0) check("R5 spacing", ev_fld[k] - ev_fld[k-1], 2);
      end
    end

    // R6 immediate: disjoint windows share a field
    set_a(1'b1, 0, 1'b0, 0, 4, 2, 4);
    set_b(1'b1, 0, 1'b0, 0, 12, 2, 4);
    sw_reset();
    run_fields(5);
    check("R6 runs logged", int'(log_n >= 6), 1);
    for (int k = 0; k + 1 < log_n; k++) begin
      check("R6 immediate field step", ev_fld[k+1] - ev_fld[k], (ev_sel[k] == 0) ? 0 : 1);
      check("R6 start line", ev_line[k], (ev_sel[k] == 0) ? 4 : 12);
    end

    // R6 immediate: overlapping windows push to next field
    set_b(1'b1, 0, 1'b0, 0, 6, 2, 4);
    sw_reset();
    run_fields(5);
    check("R6 overlap runs logged", int'(log_n >= 4), 1);
    for (int k = 1; k < log_n; k++)
      check("R6 overlap waits a field", ev_fld[k] - ev_fld[k-1], 1);

    // R11 software reset during a run
    set_a(1'b1, 1, 1'b0, 0, 4, 2, 4);
    set_b(1'b1, 1, 1'b0, 0, 4, 2, 4);
    sw_reset();
    wait_runs(2);
    repeat (5) @(negedge clk);
    check("R11 run in progress", int'(task_active), 1);
    sw_rst_n = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    check("R11 active cleared", int'(task_active), 0);
    check("R11 toggle cleared", int'(toggle), 0);
    check("R11 sel back to B", int'(task_sel), 1);
    sw_rst_n = 1'b1;
    repeat (2) @(negedge clk);
    log_n = 0;
    wait_runs(1);
    check("R3 B first after sw reset", ev_sel[0], 1);
    check("R10 toggle after sw reset", ev_tog[0], 1);

    // R12 reprogramming during a run
    set_a(1'b1, 1, 1'b0, 0, 4, 2, 4);
    set_b(1'b0, 1, 1'b0, 0, 4, 2, 4);
    sw_reset();
    wait_runs(1);
    a_ylen = LW'(10);
    run_fields(3);
    check("R12 runs logged", int'(log_n >= 2), 1);
    check("R12 current run unchanged", ev_len[0], 4 * NP);
    check("R12 next run uses new height", ev_len[1], 10 * NP);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule